// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the serial front end of a small serial memory. After the front end decodes a data-write command and its start address, the block gathers the incoming data bytes into a page-sized buffer. Every byte lands at an offset inside one fixed page. The page is chosen by the upper bits of the start address. The offset starts at the low bits of the start address and advances by one per byte. When the offset passes the top of the page it wraps to offset zero and overwrites what was buffered there.

The front end reports the end of the command by raising chip select. If at least one whole byte arrived and the transfer stopped on a byte boundary, the block begins a self-timed programming cycle. That cycle lasts a programmable number of system clocks. During its first cycles the block copies each buffered slot to the storage array, one slot per clock. It copies only the slots that were actually written. A status-register write uses the same timed cycle but touches no array location. The busy flag feeds the status register. A one-clock pulse in the last busy cycle clears the write-enable latch. While busy, the block accepts status reads only and ignores all other commands, data and chip-select edges.

Top module: `page_write_commit`

## Requirements
- R1: While reset is asserted and in the cycle after, `busy`, `mem_we` and `wel_clr` are all 0.
- R2: Data bytes of one write go to consecutive in-page offsets starting at `start_addr[PAGE_W-1:0]`. Every commit address carries the upper bits `start_addr[ADDR_W-1:PAGE_W]` unchanged.
- R3: When more bytes arrive than fit between the start offset and the end of the page, the offset wraps to 0. A later byte for the same offset replaces the earlier one, so only the last value is committed.
- R4: Only offsets written during the transfer are committed, each exactly once. Offset k is written in busy cycle k (counting from 0), with `mem_addr[PAGE_W-1:0]` equal to k.
- R5: A cycle starts only on a rising `cs_n` with `at_byte_edge` = 1 after at least one data byte (or a status byte). If `at_byte_edge` is 0, or no byte arrived, the write is dropped and `busy` stays 0.
- R6: `busy` rises in the clock after the edge that samples `cs_n` rising. It then stays high for exactly CYCLE_CLKS clocks.
- R7: `wel_clr` pulses for one clock, in the last busy cycle, once per programming cycle of either kind.
- R8: While `busy`, `op_accept` equals `op_valid & op_is_rdsr`. Write commands, data strobes, status strobes and chip-select edges have no effect. When idle, `op_accept` equals `op_valid`.
- R9: A status write (`sr_stb` then rising `cs_n`) runs a full timed cycle with `wel_clr` but no `mem_we`, even if stale bytes remain in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select level, already synchronized, active low |
| at_byte_edge | input | 1 | 1 when the front end's bit count is on a byte boundary |
| op_valid | input | 1 | A decoded opcode is offered |
| op_is_rdsr | input | 1 | The offered opcode is a status read |
| op_accept | output | 1 | The offered opcode may proceed |
| wr_start | input | 1 | Data-write command and address received (pulse) |
| start_addr | input | ADDR_W | Start address of the data write |
| data_stb | input | 1 | One data byte received (pulse) |
| data_byte | input | 8 | Received data byte |
| sr_stb | input | 1 | Status-register write byte received (pulse) |
| busy | output | 1 | Programming cycle in progress (status bit 0) |
| wel_clr | output | 1 | Clear the write-enable latch (pulse) |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with a 6-bit address, an 8-byte page and a 12-clock cycle. This gives eight pages of eight offsets. With that setup the bench can sweep every start offset on two pages, with byte counts of one, three, a full page and a page plus three. That covers every wrap point and every overwrite pattern. The short cycle also lets the bench count the exact busy length and commit order for each write. It can inject ignored commands inside the busy window, and check dropped writes and status cycles with stale buffer contents.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Kind of programming cycle latched when chip select rises.
  typedef enum logic [1:0] {
    CK_NONE   = 2'd0,
    CK_ARRAY  = 2'd1,
    CK_STATUS = 2'd2
  } commit_kind_t;
endpackage

// File: rtl/pwb_slot_buf.sv
module pwb_slot_buf #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_slot,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [PAGE_BYTES-1:0] valid_vec;
  logic [DATA_W-1:0]     data_arr [PAGE_BYTES];

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic              vld_q;
    logic [DATA_W-1:0] byte_q;
    logic              hit;

    assign hit = wr_en && (wr_slot == PAGE_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q <= 1'b0;
      else if (clear) vld_q <= 1'b0;
      else if (hit)   vld_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) byte_q <= wr_data;
    end

    assign valid_vec[s] = vld_q;
    assign data_arr[s]  = byte_q;
  end

  assign rd_valid = valid_vec[rd_slot];
  assign rd_data  = data_arr[rd_slot];
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int CYCLE_CLKS = 16,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] count,
  output logic             last
);
  assign last = busy && (count == CNT_W'(CYCLE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      count <= '0;
    end else if (last) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (busy) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/page_write_commit.sv
module page_write_commit #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 5,
  parameter int CYCLE_CLKS = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              at_byte_edge,
  input  logic              op_valid,
  input  logic              op_is_rdsr,
  output logic              op_accept,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              data_stb,
  input  logic [7:0]        data_byte,
  input  logic              sr_stb,
  output logic              busy,
  output logic              wel_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  import pwb_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - PAGE_W;
  localparam int CNT_MAX    = (CYCLE_CLKS > PAGE_BYTES) ? CYCLE_CLKS : PAGE_BYTES;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  // In-page offset arithmetic: wraps inside the page, page bits untouched.
  function automatic logic [PAGE_W-1:0] next_slot(input logic [PAGE_W-1:0] s);
    return s + PAGE_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [HI_W-1:0] pg,
                                                   input logic [PAGE_W-1:0] s);
    return {pg, s};
  endfunction

  // Named internal events
  logic cs_q, cs_rise;
  logic wr_ok, byte_ok, sr_ok, commit_go;
  logic wr_open, have_data, sr_pend;
  logic [HI_W-1:0]   page_q;
  logic [PAGE_W-1:0] slot_ptr;
  commit_kind_t      kind_q;
  logic [CNT_W-1:0]  cyc_cnt;
  logic              cyc_last, in_copy, array_mode;
  logic              rd_valid;
  logic [7:0]        rd_data;
  logic [PAGE_W-1:0] rd_slot;

  assign cs_rise   = cs_n && !cs_q;
  assign wr_ok     = wr_start && !busy;
  assign byte_ok   = data_stb && !busy && wr_open;
  assign sr_ok     = sr_stb && !busy;
  assign commit_go = cs_rise && !busy && at_byte_edge && (have_data || sr_pend);
  assign op_accept = op_valid && (!busy || op_is_rdsr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      wr_open   <= 1'b0;
      have_data <= 1'b0;
      sr_pend   <= 1'b0;
      page_q    <= '0;
      slot_ptr  <= '0;
      kind_q    <= CK_NONE;
    end else begin
      cs_q <= cs_n;
      if (commit_go) kind_q <= have_data ? CK_ARRAY : CK_STATUS;
      if (cs_rise) begin
        wr_open   <= 1'b0;
        have_data <= 1'b0;
        sr_pend   <= 1'b0;
      end else if (wr_ok) begin
        wr_open   <= 1'b1;
        have_data <= 1'b0;
        page_q    <= start_addr[ADDR_W-1:PAGE_W];
        slot_ptr  <= start_addr[PAGE_W-1:0];
      end else begin
        if (byte_ok) begin
          have_data <= 1'b1;
          slot_ptr  <= next_slot(slot_ptr);
        end
        if (sr_ok) sr_pend <= 1'b1;
      end
    end
  end

  pwb_slot_buf #(.PAGE_W(PAGE_W), .DATA_W(8)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (wr_ok),
    .wr_en    (byte_ok),
    .wr_slot  (slot_ptr),
    .wr_data  (data_byte),
    .rd_slot  (rd_slot),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  pwb_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS), .CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_go),
    .busy  (busy),
    .count (cyc_cnt),
    .last  (cyc_last)
  );

  assign rd_slot    = cyc_cnt[PAGE_W-1:0];
  assign in_copy    = cyc_cnt < CNT_W'(PAGE_BYTES);
  assign array_mode = (kind_q == CK_ARRAY);
  assign mem_we     = busy && array_mode && in_copy && rd_valid;
  assign mem_addr   = join_addr(page_q, rd_slot);
  assign mem_wdata  = rd_data;
  assign wel_clr    = cyc_last;
endmodule

// File: rtl/page_write_commit_chk.sv
module page_write_commit_chk #(
  parameter int CYCLE_CLKS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic busy,
  input logic wel_clr,
  input logic mem_we,
  input logic op_valid,
  input logic op_is_rdsr,
  input logic op_accept
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= 0;
    else if (!busy) run_len <= 0;
    else            run_len <= run_len + 1;
  end

  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R4
  AST_START_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs_n) && !$past(cs_n, 2))); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wel_clr) |=> busy); // R6
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == CYCLE_CLKS)); // R6
  AST_WEL_ENDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy); // R7
  AST_WEL_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> busy); // R7
  AST_ACCEPT_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_accept) |-> (op_valid && op_is_rdsr)); // R8
endmodule

bind page_write_commit page_write_commit_chk #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .busy       (busy),
  .wel_clr    (wel_clr),
  .mem_we     (mem_we),
  .op_valid   (op_valid),
  .op_is_rdsr (op_is_rdsr),
  .op_accept  (op_accept)
);

// File: tb/page_write_commit_tb.sv
module page_write_commit_tb;
  localparam int TB_ADDR_W = 6;
  localparam int TB_PAGE_W = 3;
  localparam int TB_CYC    = 12;
  localparam int PB        = 1 << TB_PAGE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, at_byte_edge = 1'b1, op_valid = 1'b0, op_is_rdsr = 1'b0;
  logic wr_start = 1'b0, data_stb = 1'b0, sr_stb = 1'b0;
  logic [TB_ADDR_W-1:0] start_addr = '0;
  logic [7:0] data_byte = '0;
  logic op_accept, busy, wel_clr, mem_we;
  logic [TB_ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int errors = 0;
  int checks = 0;

  // observation results
  int obs_len, obs_wel, obs_we, obs_first, obs_bad_order, obs_bad_page;
  int got_seen [PB];
  int got_data [PB];
  int exp_v [PB];
  int exp_d [PB];

  always #4 clk = ~clk;

  page_write_commit #(.ADDR_W(TB_ADDR_W), .PAGE_W(TB_PAGE_W), .CYCLE_CLKS(TB_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .at_byte_edge(at_byte_edge),
    .op_valid(op_valid), .op_is_rdsr(op_is_rdsr), .op_accept(op_accept),
    .wr_start(wr_start), .start_addr(start_addr), .data_stb(data_stb),
    .data_byte(data_byte), .sr_stb(sr_stb), .busy(busy), .wel_clr(wel_clr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pat(input int st, input int i);
    return (st * 37 + i * 11 + 5) & 8'hFF;
  endfunction

  // Watch a fixed window after the chip-select rise, sampled after each edge.
  task automatic observe(input int exp_page);
    obs_len = 0; obs_wel = 0; obs_we = 0; obs_first = 0;
    obs_bad_order = 0; obs_bad_page = 0;
    for (int s = 0; s < PB; s++) begin got_seen[s] = 0; got_data[s] = -1; end
    for (int k = 0; k < TB_CYC + 3; k++) begin
      @(posedge clk); #2;
      if (k == 0) obs_first = busy;
      if (busy) obs_len++;
      if (wel_clr) obs_wel++;
      if (mem_we) begin
        obs_we++;
        if (int'(mem_addr[TB_PAGE_W-1:0]) != obs_len - 1) obs_bad_order++;
        if (int'(mem_addr[TB_ADDR_W-1:TB_PAGE_W]) != exp_page) obs_bad_page++;
        got_seen[mem_addr[TB_PAGE_W-1:0]]++;
        got_data[mem_addr[TB_PAGE_W-1:0]] = int'(mem_wdata);
      end
    end
  endtask

  task automatic send_write(input int st, input int n, input bit aligned);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); wr_start = 1'b1; start_addr = TB_ADDR_W'(st);
    @(negedge clk); wr_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      data_stb = 1'b1; data_byte = 8'(pat(st, i));
      @(negedge clk); data_stb = 1'b0;
      @(negedge clk);
    end
    at_byte_edge = aligned; cs_n = 1'b1;
  endtask

  task automatic build_model(input int st, input int n);
    for (int s = 0; s < PB; s++) begin exp_v[s] = 0; exp_d[s] = 0; end
    for (int i = 0; i < n; i++) begin
      exp_v[(st + i) % PB] = 1;
      exp_d[(st + i) % PB] = pat(st, i);
    end
  endtask

  task automatic compare_commit(input int n);
    int nv = 0;
    string rq;
    rq = (n > PB - 0) ? "R3" : "R2";
    for (int s = 0; s < PB; s++) nv += exp_v[s];
    check(obs_first == 1, "R6 busy start", obs_first, 1);
    check(obs_len == TB_CYC, "R6 busy length", obs_len, TB_CYC);
    check(obs_wel == 1, "R7 wel pulses", obs_wel, 1);
    check(obs_we == nv, "R4 commit count", obs_we, nv);
    check(obs_bad_order == 0, "R4 commit order", obs_bad_order, 0);
    check(obs_bad_page == 0, "R2 page bits", obs_bad_page, 0);
    for (int s = 0; s < PB; s++) begin
      check(got_seen[s] == exp_v[s], "R4 slot written", got_seen[s], exp_v[s]);
      if (exp_v[s] == 1)
        check(got_data[s] == exp_d[s], rq, got_data[s], exp_d[s]);
    end
  endtask

  task automatic idle(input int n);
    at_byte_edge = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk); #2;
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
    check(wel_clr == 1'b0, "R1 wel_clr", wel_clr, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check(busy == 1'b0 && wel_clr == 1'b0 && mem_we == 1'b0, "R1 after release",
          int'(busy), 0);

    // R8 idle acceptance
    @(negedge clk); op_valid = 1'b1; op_is_rdsr = 1'b0; #1;
    check(op_accept == 1'b1, "R8 idle accept", op_accept, 1);
    @(negedge clk); op_valid = 1'b0;

    // R2 R3 R4 R6 R7 sweep
    foreach (exp_v[i]) exp_v[i] = 0;
    for (int pg = 0; pg < 8; pg += 5) begin
      for (int off = 0; off < PB; off++) begin
        for (int ni = 0; ni < 4; ni++) begin
          int n;
          int st;
          n  = (ni == 0) ? 1 : (ni == 1) ? 3 : (ni == 2) ? PB : PB + 3;
          st = pg * PB + off;
          build_model(st, n);
          send_write(st, n, 1'b1);
          observe(pg);
          compare_commit(n);
          idle(2);
        end
      end
    end

    // R5: misaligned chip-select rise drops the write
    for (int st = 0; st < 24; st += 7) begin
      send_write(st, 2, 1'b0);
      observe(st / PB);
      check(obs_len == 0, "R5 misaligned busy", obs_len, 0);
      check(obs_we == 0 && obs_wel == 0, "R5 misaligned commit", obs_we + obs_wel, 0);
      idle(2);
    end

    // R5: command with no data byte
    send_write(9, 0, 1'b1);
    observe(1);
    check(obs_len == 0, "R5 empty write busy", obs_len, 0);
    idle(2);

    // R9: status write after stale buffer content
    build_model(40, 4);
    send_write(40, 4, 1'b1);
    observe(5);
    compare_commit(4);
    idle(2);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); sr_stb = 1'b1;
    @(negedge clk); sr_stb = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    observe(5);
    check(obs_len == TB_CYC, "R9 status busy length", obs_len, TB_CYC);
    check(obs_we == 0, "R9 no array write", obs_we, 0);
    check(obs_wel == 1, "R7 R9 status wel pulse", obs_wel, 1);
    idle(2);

    // R8: traffic during busy is ignored
    build_model(16, 2);
    send_write(16, 2, 1'b1);
    fork
      observe(2);
      begin
        @(negedge clk); op_valid = 1'b1; op_is_rdsr = 1'b0; #1;
        check(op_accept == 1'b0, "R8 busy reject", op_accept, 0);
        @(negedge clk); op_is_rdsr = 1'b1; #1;
        check(op_accept == 1'b1, "R8 busy rdsr", op_accept, 1);
        @(negedge clk); op_valid = 1'b0; op_is_rdsr = 1'b0; cs_n = 1'b0;
        @(negedge clk); wr_start = 1'b1; start_addr = TB_ADDR_W'(21);
        @(negedge clk); wr_start = 1'b0; data_stb = 1'b1; data_byte = 8'hA5;
        @(negedge clk); data_stb = 1'b0; sr_stb = 1'b1;
        @(negedge clk); sr_stb = 1'b0;
        @(negedge clk); cs_n = 1'b1;
      end
    join
    compare_commit(2);
    obs_len = 0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #2;
      if (busy) obs_len++;
    end
    check(obs_len == 0, "R8 no cycle from busy traffic", obs_len, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule